// File: doc/BRIEF.md
# Ripple Wake-Up Power-Gating Sequencer

This block controls the sleep switches of a linear pipeline that is split into a configurable number of clusters, each with its own stage count, wake latency and forward propagation delay. All clusters stay gated while the pipeline is empty. When a token requests entry, only the head cluster is woken. The token is held off until that cluster is ready. Every cluster that becomes ready then wakes a cluster further down, at a configurable look-ahead distance. The wake-up therefore travels down the pipeline ahead of the first token, and every ramp after the head one is hidden behind forward propagation.

Each cluster's supply ramp is modelled as a countdown of its wake latency. A cluster counts as ready only when that countdown has finished and its external power-good input is high. An occupancy counter, incremented by accepted tokens and decremented by departing ones, detects an empty pipeline and gates every cluster at once. A trip monitor follows the first token after each full sleep, using the per-cluster forward delays. It flags any cluster that the token would reach before that cluster is ready.

Top module: `ripple_pg_seq`

## Requirements
- R1: After reset, `sleep_o` is all ones (bit c high means cluster c is gated), `pwr_rdy_o` and `late_o` are all zero, `occ_o` is zero and `tok_stall_o` is high.
- R2: While every cluster is gated, only a high `tok_req_i` wakes anything: on the next edge only `sleep_o[0]` clears. `pwr_rdy_o[0]` rises WAKE_LAT[0] edges after that.
- R3: A gated cluster j > 0 is woken on the edge after its source cluster is ready. The source is cluster j-LOOKAHEAD, or cluster 0 when j < LOOKAHEAD. Its `pwr_rdy_o[j]` rises WAKE_LAT[j] edges after it is woken.
- R4: `tok_stall_o` is high while cluster 0 is not ready or occupancy equals DEPTH. A request is accepted at an edge only when `tok_req_i` is high and `tok_stall_o` is low.
- R5: Occupancy rises by one on an accepted token and falls by one on `tok_out_i`. It is unchanged when both occur at the same edge.
- R6: `tok_out_i` while occupancy is zero is ignored, and occupancy stays zero.
- R7: On the edge following a cycle with zero occupancy and `tok_req_i` low, every `sleep_o` bit goes high together and every ready bit drops.
- R8: The first token accepted after a full sleep starts a trip that clears `late_o`. Cluster c is late when it is not ready ARR[c] edges after the accept, where ARR[c] is the sum of FWD_DLY over clusters below c. `late_o[c]` is then set and stays set until the next trip.
- R9: A cluster whose `pg_i` bit is low never reports ready, even after its countdown has finished, and so does not wake its downstream cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_req_i | input | 1 | Token waiting to enter the pipeline |
| tok_stall_o | output | 1 | Entry held off; no token accepted this edge |
| tok_out_i | input | 1 | Token leaving the last stage |
| pg_i | input | N_CL | External power-good per cluster |
| sleep_o | output | N_CL | Sleep command per cluster, 1 = gated |
| pwr_rdy_o | output | N_CL | Cluster ramp finished and power good |
| late_o | output | N_CL | First token reached the cluster before it was ready |
| occ_o | output | OCC_W | Tokens currently in the pipeline |

## Verification
A countdown that is off by one moves the cycle in which a `pwr_rdy_o` bit rises. Because each ready bit starts the next wake, that error adds up along the ripple and reaches the last cluster several cycles away from the computed instant. A corrupted occupancy count appears at `occ_o` on the next edge. Under that fault the pipeline either gates itself with tokens still inside or never returns to all-sleep after draining, and this shows one edge after the final departure. A faulty trip monitor raises `late_o` when the default timing meets the budget exactly, or stays silent when a power-good input is held low through the whole trip.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  // width of each per-cluster field in the packed timing parameters
  localparam int unsigned FLD_W = 8;

  // occupancy update selected for one clock edge
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_INC  = 2'b01,
    OCC_DEC  = 2'b10,
    OCC_SWAP = 2'b11
  } occ_ev_e;
endpackage

// File: rtl/pgs_wake_ctrl.sv
module pgs_wake_ctrl
  import pgs_pkg::*;
#(
  parameter int unsigned N_CL      = 3,
  parameter int unsigned LOOKAHEAD = 1,
  parameter logic [N_CL*FLD_W-1:0] WAKE_LAT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wake_head_i,
  input  logic            sleep_all_i,
  input  logic [N_CL-1:0] pg_i,
  output logic [N_CL-1:0] sleep_o,
  output logic [N_CL-1:0] rdy_o
);

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    localparam logic [FLD_W-1:0] LAT = WAKE_LAT[c*FLD_W +: FLD_W];

    logic             trig;
    logic             sleep_q, sleep_d;
    logic [FLD_W-1:0] cnt_q, cnt_d;

    // choose what wakes this cluster
    if (c == 0) begin : g_head
      assign trig = wake_head_i;
    end else if (c >= LOOKAHEAD) begin : g_far
      assign trig = rdy_o[c-LOOKAHEAD];
    end else begin : g_near
      assign trig = rdy_o[0];
    end

    always_comb begin
      sleep_d = sleep_q;
      cnt_d   = cnt_q;
      if (sleep_all_i) begin
        sleep_d = 1'b1;
        cnt_d   = '0;
      end else if (sleep_q && trig) begin
        sleep_d = 1'b0;
        cnt_d   = LAT;
      end else if (!sleep_q && (cnt_q != '0)) begin
        cnt_d   = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sleep_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        sleep_q <= sleep_d;
        cnt_q   <= cnt_d;
      end
    end

    assign sleep_o[c] = sleep_q;
    assign rdy_o[c]   = ~sleep_q & (cnt_q == '0) & pg_i[c];
  end

endmodule

// File: rtl/pgs_occ_cnt.sv
module pgs_occ_cnt
  import pgs_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_i,
  input  logic             out_i,
  output logic [OCC_W-1:0] occ_o,
  output logic             empty_o,
  output logic             full_o
);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic             out_ok;
  occ_ev_e          ev;

  assign out_ok = out_i && (occ_q != '0);
  assign ev     = occ_ev_e'({out_ok, in_i});

  always_comb begin
    occ_d = occ_q;
    case (ev)
      OCC_INC:  occ_d = occ_q + 1'b1;
      OCC_DEC:  occ_d = occ_q - 1'b1;
      default:  occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_d;
    end
  end

  assign occ_o   = occ_q;
  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == OCC_W'(DEPTH));

endmodule

// File: rtl/pgs_trip_mon.sv
module pgs_trip_mon
  import pgs_pkg::*;
#(
  parameter int unsigned N_CL = 3,
  parameter logic [N_CL*FLD_W-1:0] FWD_DLY = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            rearm_i,
  input  logic [N_CL-1:0] rdy_i,
  output logic [N_CL-1:0] late_o
);

  // edges from the first accept until the token reaches cluster idx
  function automatic int unsigned arrive_at(input int unsigned idx);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < idx; k++) begin
      s += int'(FWD_DLY[k*FLD_W +: FLD_W]);
    end
    return s;
  endfunction

  localparam int unsigned ARR_LAST = arrive_at(N_CL - 1);
  localparam int unsigned TRIP_W   = $clog2(ARR_LAST + 2);

  logic              armed_q, armed_d;
  logic              run_q, run_d;
  logic [TRIP_W-1:0] cnt_q, cnt_d;
  logic [N_CL-1:0]   late_q, late_d;
  logic [N_CL-1:0]   hit;
  logic              start;

  for (genvar c = 0; c < N_CL; c++) begin : g_hit
    localparam logic [TRIP_W-1:0] ARR_C = TRIP_W'(arrive_at(c));
    assign hit[c] = run_q && (cnt_q == ARR_C) && !rdy_i[c];
  end

  assign start = accept_i && armed_q;

  always_comb begin
    armed_d = armed_q;
    run_d   = run_q;
    cnt_d   = cnt_q;
    late_d  = late_q;
    if (rearm_i) begin
      armed_d = 1'b1;
      run_d   = 1'b0;
    end else if (start) begin
      armed_d = 1'b0;
      run_d   = 1'b1;
      cnt_d   = '0;
      late_d  = '0;
    end else if (run_q) begin
      late_d = late_q | hit;
      if (cnt_q == TRIP_W'(ARR_LAST)) begin
        run_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      run_q   <= 1'b0;
      cnt_q   <= '0;
      late_q  <= '0;
    end else begin
      armed_q <= armed_d;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      late_q  <= late_d;
    end
  end

  assign late_o = late_q;

endmodule

// File: rtl/ripple_pg_seq.sv
module ripple_pg_seq
  import pgs_pkg::*;
#(
  parameter int unsigned N_CL      = 3,
  parameter int unsigned LOOKAHEAD = 1,
  parameter int unsigned DEPTH     = 10,
  // per-cluster fields of FLD_W bits, cluster 0 in the low bits
  parameter logic [N_CL*FLD_W-1:0] WAKE_LAT = 24'h04_06_03,
  parameter logic [N_CL*FLD_W-1:0] FWD_DLY  = 24'h04_06_06,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_req_i,
  output logic             tok_stall_o,
  input  logic             tok_out_i,
  input  logic [N_CL-1:0]  pg_i,
  output logic [N_CL-1:0]  sleep_o,
  output logic [N_CL-1:0]  pwr_rdy_o,
  output logic [N_CL-1:0]  late_o,
  output logic [OCC_W-1:0] occ_o
);

  logic accept;
  logic sleep_all;
  logic occ_empty;
  logic occ_full;

  assign tok_stall_o = ~pwr_rdy_o[0] | occ_full;
  assign accept      = tok_req_i & ~tok_stall_o;
  assign sleep_all   = occ_empty & ~tok_req_i;

  pgs_wake_ctrl #(
    .N_CL      (N_CL),
    .LOOKAHEAD (LOOKAHEAD),
    .WAKE_LAT  (WAKE_LAT)
  ) wake_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_head_i (tok_req_i),
    .sleep_all_i (sleep_all),
    .pg_i        (pg_i),
    .sleep_o     (sleep_o),
    .rdy_o       (pwr_rdy_o)
  );

  pgs_occ_cnt #(
    .DEPTH (DEPTH)
  ) occ_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_i    (accept),
    .out_i   (tok_out_i),
    .occ_o   (occ_o),
    .empty_o (occ_empty),
    .full_o  (occ_full)
  );

  pgs_trip_mon #(
    .N_CL    (N_CL),
    .FWD_DLY (FWD_DLY)
  ) trip_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .rearm_i  (sleep_all),
    .rdy_i    (pwr_rdy_o),
    .late_o   (late_o)
  );

endmodule

// File: rtl/ripple_pg_seq_chk.sv
module ripple_pg_seq_chk #(
  parameter int unsigned N_CL      = 3,
  parameter int unsigned LOOKAHEAD = 1,
  parameter int unsigned DEPTH     = 10,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tok_req_i,
  input logic             tok_stall_o,
  input logic             tok_out_i,
  input logic [N_CL-1:0]  pg_i,
  input logic [N_CL-1:0]  sleep_o,
  input logic [N_CL-1:0]  pwr_rdy_o,
  input logic [N_CL-1:0]  late_o,
  input logic [OCC_W-1:0] occ_o
);

  // R2
  head_wake_only_by_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_o[0] && !tok_req_i) |=> sleep_o[0]);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_o == OCC_W'(DEPTH) && !tok_out_i) |=> occ_o == OCC_W'(DEPTH));

  // R5
  occ_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_req_i && !tok_stall_o && !tok_out_i) |=> occ_o == $past(occ_o) + 1'b1);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_o == '0 && !tok_req_i) |=> occ_o == '0);

  // R7
  sleep_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_o == '0 && !tok_req_i) |=> (&sleep_o) && (pwr_rdy_o == '0));

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    // R9
    rdy_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_rdy_o[c] |-> (!sleep_o[c] && pg_i[c]));

    if (c > 0) begin : g_tail
      localparam int unsigned SRC = (c >= LOOKAHEAD) ? c - LOOKAHEAD : 0;
      // R3
      ripple_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o[c] && !pwr_rdy_o[SRC]) |=> sleep_o[c]);
    end
  end

endmodule

bind ripple_pg_seq ripple_pg_seq_chk #(
  .N_CL      (N_CL),
  .LOOKAHEAD (LOOKAHEAD),
  .DEPTH     (DEPTH)
) chk_i (.*);

// File: tb/ripple_pg_seq_tb_top.sv
module ripple_pg_seq_tb_top;

  localparam int unsigned N_CL  = 3;
  localparam int unsigned DEPTH = 10;
  localparam int unsigned OCC_W = $clog2(DEPTH + 1);
  localparam int LAT [3] = '{3, 6, 4};
  localparam int FWD [3] = '{6, 6, 4};

  logic             clk;
  logic             rst_n;
  logic             tok_req_i;
  logic             tok_stall_o;
  logic             tok_out_i;
  logic [N_CL-1:0]  pg_i;
  logic [N_CL-1:0]  sleep_o;
  logic [N_CL-1:0]  pwr_rdy_o;
  logic [N_CL-1:0]  late_o;
  logic [OCC_W-1:0] occ_o;

  int checks;
  int failures;
  bit done;

  ripple_pg_seq #(
    .N_CL      (N_CL),
    .LOOKAHEAD (1),
    .DEPTH     (DEPTH),
    .WAKE_LAT  (24'h04_06_03),
    .FWD_DLY   (24'h04_06_06)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_req_i   (tok_req_i),
    .tok_stall_o (tok_stall_o),
    .tok_out_i   (tok_out_i),
    .pg_i        (pg_i),
    .sleep_o     (sleep_o),
    .pwr_rdy_o   (pwr_rdy_o),
    .late_o      (late_o),
    .occ_o       (occ_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drain_one();
    @(negedge clk); tok_out_i = 1'b1;
    @(negedge clk); tok_out_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tok_req_i = 1'b0; tok_out_i = 1'b0; pg_i = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sleep_o == 3'b111, "R1 sleep", int'(sleep_o), 7);
    check(pwr_rdy_o == 3'b000 && late_o == 3'b000, "R1 rdy/late", int'({pwr_rdy_o, late_o}), 0);
    check(occ_o == 0 && tok_stall_o, "R1 occ/stall", int'({occ_o, tok_stall_o}), 1);
  endtask

  // one token through a sleeping pipeline; pg_mask selects clusters with power good
  task automatic t_trip(input logic [2:0] pg_mask);
    int first [3];
    int exp_first [3];
    int a0;
    logic [2:0] exp_late;
    pg_i = pg_mask;
    // expected ready instants, in edges counted from the request
    exp_first[0] = pg_mask[0] ? LAT[0] + 1 : 0;
    for (int c = 1; c < 3; c++) begin
      exp_first[c] = (pg_mask[c] && exp_first[c-1] != 0) ? exp_first[c-1] + 1 + LAT[c] : 0;
    end
    a0 = exp_first[0];
    for (int c = 0; c < 3; c++) begin
      int arr;
      arr = 0;
      for (int k = 0; k < c; k++) arr += FWD[k];
      exp_late[c] = (exp_first[c] == 0) || (exp_first[c] > a0 + 1 + arr);
      first[c] = 0;
    end
    @(negedge clk);
    tok_req_i = 1'b1;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) if (pwr_rdy_o[c] && first[c] == 0) first[c] = n;
      if (n == 1) check(sleep_o == 3'b110, "R2 head only", int'(sleep_o), 6);
      if (n == a0 - 1) check(tok_stall_o == 1'b1, "R4 stall before ready", int'(tok_stall_o), 1);
      if (n == a0) check(tok_stall_o == 1'b0, "R4 stall released", int'(tok_stall_o), 0);
      if (n == a0 + 1) begin
        tok_req_i = 1'b0;
        check(occ_o == 1, "R5 accept", int'(occ_o), 1);
      end
    end
    for (int c = 0; c < 3; c++) begin
      check(first[c] == exp_first[c], c == 0 ? "R2 head ready" : "R3 ripple ready", first[c], exp_first[c]);
    end
    check(late_o == exp_late, "R8 late flags", int'(late_o), int'(exp_late));
    if (!pg_mask[1]) check(pwr_rdy_o[1] == 1'b0 && sleep_o[1] == 1'b0, "R9 pg low",
                           int'({sleep_o[1], pwr_rdy_o[1]}), 0);
    pg_i = '1;
    drain_one();
    check(occ_o == 0 && sleep_o != 3'b111, "R5 drain", int'({occ_o, sleep_o}), 0);
    @(negedge clk);
    check(sleep_o == 3'b111 && pwr_rdy_o == 3'b000, "R7 sleep all", int'({sleep_o, pwr_rdy_o}), 56);
  endtask

  task automatic t_burst();
    @(negedge clk);
    tok_req_i = 1'b1;
    repeat (40) @(negedge clk);
    check(occ_o == OCC_W'(DEPTH) && tok_stall_o, "R4 full stall", int'(occ_o), int'(DEPTH));
    tok_out_i = 1'b1;
    @(negedge clk);
    tok_out_i = 1'b0; tok_req_i = 1'b0;
    check(occ_o == OCC_W'(DEPTH - 1) && !tok_stall_o, "R5 decrement", int'(occ_o), int'(DEPTH - 1));
    @(negedge clk);
    tok_req_i = 1'b1; tok_out_i = 1'b1;
    @(negedge clk);
    tok_req_i = 1'b0; tok_out_i = 1'b0;
    check(occ_o == OCC_W'(DEPTH - 1), "R5 simultaneous", int'(occ_o), int'(DEPTH - 1));
    for (int i = 0; i < int'(DEPTH) - 1; i++) drain_one();
    check(occ_o == 0, "R5 burst drained", int'(occ_o), 0);
    @(negedge clk);
    check(sleep_o == 3'b111, "R7 sleep after burst", int'(sleep_o), 7);
  endtask

  task automatic t_underflow();
    drain_one();
    check(occ_o == 0, "R6 underflow ignored", int'(occ_o), 0);
    check(sleep_o == 3'b111, "R6 still asleep", int'(sleep_o), 7);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_trip(3'b111);
    t_trip(3'b101);
    t_trip(3'b111);
    t_burst();
    t_underflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule